// File: doc/BRIEF.md
# UART Channel Register and Command Block

This block is the byte-wide register front end of one UART channel. A host bus reads and writes byte registers inside a 64-byte window, selected by the low six address bits. The block holds two mode registers that share one offset, tracks transmitter and receiver enables, and decodes a packed command byte into housekeeping, transmitter and receiver actions. It also keeps a one-byte transmit holding buffer and collects interrupt sources behind a mask into a single interrupt line.

The receive FIFO lives outside the block. This block reads the FIFO's not-empty and full flags and its head byte. It pops the FIFO on a data read and flushes it on a receiver reset. The transmit byte leaves on a valid/ready stream. Baud divisor bytes come in from outside and can only be read here.

Top module: `uart_regif`

## Requirements
- R1: After reset, the status register reads 0x08 with the FIFO empty. The interrupt status, the mask and both mode registers read 0x00, and tx_valid, rx_en and irq are low.
- R2: Offset 0x00 is shared by the two mode registers. A write stores into the register that the pointer selects and then points to the second register. A read returns the selected register. Command misc code 1 points back at the first register.
- R3: The status register at offset 0x04 has bit0 = FIFO not empty, bit1 = FIFO full, bit2 = transmitter enabled (ready) and bit3 = transmit buffer empty. Bits 7:4 read 0.
- R4: A write to offset 0x0C loads the transmit byte and clears the empty bit. While the transmitter is enabled and the buffer is not empty, tx_valid is high with the byte held stable. The empty bit sets in the cycle after tx_valid and tx_ready are both high.
- R5: Command bits [3:2] drive the transmitter: 1 enables it, 2 disables it, and 0 or 3 leaves it unchanged. A disabled transmitter keeps its byte and drops tx_valid.
- R6: Command bits [1:0] drive the receiver enable rx_en with the same encoding.
- R7: Command bits [6:4] are a misc code. Code 2 disables the receiver and pulses rxq_flush during the write. Code 3 disables the transmitter and marks the buffer empty. The misc field acts before the transmitter and receiver fields of the same write, so one write can both reset and enable.
- R8: A pulse on brk_evt sets interrupt status bit2. Misc code 5 clears it. Codes 0, 4, 6 and 7 change nothing.
- R9: Interrupt status at offset 0x14 has bit0 = transmitter ready. Bit1 = FIFO full when bit6 of the first mode register is 1, and FIFO not empty otherwise. A write to 0x14 sets the mask, and irq is high when status AND mask is nonzero.
- R10: A read of offset 0x0C returns the FIFO head and drives rxq_pop for that one cycle when the FIFO is not empty. When the FIFO is empty it returns 0x00 and does not pop.
- R11: Offsets 0x18 and 0x1C return baud_a and baud_b. Other unmapped offsets read 0x00, and writes to 0x04 and 0x10 change nothing.
- R12: Read data appears on rd_data in the cycle after the read strobe and holds until the next read. Register effects of a write show on the ports in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address, low six bits decoded |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| rxq_data | input | 8 | Receive FIFO head byte |
| rxq_avail | input | 1 | Receive FIFO not empty |
| rxq_full | input | 1 | Receive FIFO full |
| rxq_pop | output | 1 | Pop the FIFO head |
| rxq_flush | output | 1 | Empty the FIFO |
| rx_en | output | 1 | Receiver enabled |
| brk_evt | input | 1 | Received-break event pulse |
| baud_a | input | 8 | First baud divisor byte |
| baud_b | input | 8 | Second baud divisor byte |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Transmit byte accepted |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Interrupt request |

## Verification
Register reads land on rd_data one clock after the strobe cycle, so the bench drives each strobe on a falling edge and samples on the next falling edge. Write effects on status, tx_valid, rx_en and irq show one clock after the write in the same way. rxq_pop and rxq_flush are combinational from the strobe cycle, so the bench samples them shortly after driving the strobe and before the rising edge. A transmit handshake sets the empty bit one edge later, and the bench checks tx_valid and status after that edge.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
   localparam int DEC_W = 6;
   localparam logic [DEC_W-1:0] OFF_MODE  = 6'h00;
   localparam logic [DEC_W-1:0] OFF_STAT  = 6'h04;
   localparam logic [DEC_W-1:0] OFF_CMD   = 6'h08;
   localparam logic [DEC_W-1:0] OFF_DATA  = 6'h0C;
   localparam logic [DEC_W-1:0] OFF_AUX   = 6'h10;
   localparam logic [DEC_W-1:0] OFF_INT   = 6'h14;
   localparam logic [DEC_W-1:0] OFF_BAUDA = 6'h18;
   localparam logic [DEC_W-1:0] OFF_BAUDB = 6'h1C;

   localparam int ST_RXRDY = 0;
   localparam int ST_FULL  = 1;
   localparam int ST_TXRDY = 2;
   localparam int ST_TXEMP = 3;

   localparam int IS_TX  = 0;
   localparam int IS_RX  = 1;
   localparam int IS_BRK = 2;

   localparam int MODE_RXSRC_BIT = 6;

   typedef enum logic [2:0] {
      MISC_NOP0   = 3'd0,
      MISC_PTRRST = 3'd1,
      MISC_RXRST  = 3'd2,
      MISC_TXRST  = 3'd3,
      MISC_NOP4   = 3'd4,
      MISC_BRKCLR = 3'd5,
      MISC_NOP6   = 3'd6,
      MISC_NOP7   = 3'd7
   } misc_e;

   typedef enum logic [1:0] {
      DIR_KEEP = 2'd0,
      DIR_ON   = 2'd1,
      DIR_OFF  = 2'd2,
      DIR_RSV  = 2'd3
   } dir_e;

   typedef struct packed {
      logic  spare;
      misc_e misc;
      dir_e  txf;
      dir_e  rxf;
   } cmd_t;
endpackage

// File: rtl/uart_regif_cmd.sv
module uart_regif_cmd
   import uart_regif_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_we,
   input  logic [7:0] cmd_byte,
   output logic       tx_en,
   output logic       rx_en,
   output logic       ptr_rst,
   output logic       rx_flush,
   output logic       tx_rst,
   output logic       brk_clr
);
   cmd_t cmd;
   logic tx_nxt, rx_nxt;

   assign cmd      = cmd_t'(cmd_byte);
   assign ptr_rst  = cmd_we && (cmd.misc == MISC_PTRRST);
   assign rx_flush = cmd_we && (cmd.misc == MISC_RXRST);
   assign tx_rst   = cmd_we && (cmd.misc == MISC_TXRST);
   assign brk_clr  = cmd_we && (cmd.misc == MISC_BRKCLR);

   // misc field first, then transmitter, then receiver
   always_comb begin
      tx_nxt = tx_en;
      rx_nxt = rx_en;
      if (cmd_we) begin
         if (tx_rst)   tx_nxt = 1'b0;
         if (rx_flush) rx_nxt = 1'b0;
         case (cmd.txf)
            DIR_ON:  tx_nxt = 1'b1;
            DIR_OFF: tx_nxt = 1'b0;
            default: ;
         endcase
         case (cmd.rxf)
            DIR_ON:  rx_nxt = 1'b1;
            DIR_OFF: rx_nxt = 1'b0;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_en <= 1'b0;
         rx_en <= 1'b0;
      end else begin
         tx_en <= tx_nxt;
         rx_en <= rx_nxt;
      end
   end

   AST_FLUSH_RX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_flush && cmd.rxf != DIR_ON) |=> !rx_en); // R7
   AST_TXRST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_rst && cmd.txf != DIR_ON) |=> !tx_en); // R7
   AST_NOP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && cmd.txf == DIR_KEEP && !tx_rst) |=> $stable(tx_en)); // R5
endmodule

// File: rtl/uart_regif_tx.sv
module uart_regif_tx #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              tx_en,
   input  logic              tx_rst,
   input  logic              tx_ready,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_empty
);
   logic [DATA_W-1:0] hold_q;
   logic              empty_q;

   assign tx_valid = tx_en && !empty_q;
   assign tx_data  = hold_q;
   assign tx_empty = empty_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q  <= '0;
         empty_q <= 1'b1;
      end else begin
         if (load) begin
            hold_q  <= load_data;
            empty_q <= 1'b0;
         end else if (tx_rst || (tx_valid && tx_ready)) begin
            empty_q <= 1'b1;
         end
      end
   end

   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready && !load) |=> $stable(tx_data)); // R4
   AST_TX_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && !load) |=> (tx_empty && !tx_valid)); // R4
   AST_TX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !tx_empty); // R4
endmodule

// File: rtl/uart_regif_irq.sv
module uart_regif_irq
   import uart_regif_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mask_we,
   input  logic [DATA_W-1:0] mask_data,
   input  logic              tx_rdy,
   input  logic              rx_avail,
   input  logic              rx_full,
   input  logic              rx_src_full,
   input  logic              brk_set,
   input  logic              brk_clr,
   output logic [DATA_W-1:0] isr,
   output logic              irq
);
   logic [DATA_W-1:0] imr_q;
   logic              brk_q;
   logic              hit;

   always_comb begin
      isr         = '0;
      isr[IS_TX]  = tx_rdy;
      isr[IS_RX]  = rx_src_full ? rx_full : rx_avail;
      isr[IS_BRK] = brk_q;
   end

   assign hit = |(isr & imr_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         imr_q <= '0;
         brk_q <= 1'b0;
      end else begin
         if (mask_we) imr_q <= mask_data;
         if (brk_set)      brk_q <= 1'b1;
         else if (brk_clr) brk_q <= 1'b0;
      end
   end

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= hit;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = hit;
         AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            (imr_q == '0) |-> !irq); // R9
      end
   endgenerate

   AST_BRK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      brk_set |=> isr[IS_BRK]); // R8
endmodule

// File: rtl/uart_regif.sv
module uart_regif
   import uart_regif_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int DATA_W  = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic [DATA_W-1:0] rxq_data,
   input  logic              rxq_avail,
   input  logic              rxq_full,
   output logic              rxq_pop,
   output logic              rxq_flush,
   output logic              rx_en,
   input  logic              brk_evt,
   input  logic [DATA_W-1:0] baud_a,
   input  logic [DATA_W-1:0] baud_b,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [DATA_W-1:0] tx_data,
   output logic              irq
);
   localparam int NUM_MODE = 2;
   localparam int PTR_W    = $clog2(NUM_MODE);

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("uart_regif: DATA_W must be 8");
      end
      if (ADDR_W < DEC_W) begin : g_bad_addr
         $error("uart_regif: ADDR_W must cover the 64-byte window");
      end
   endgenerate

   logic [DEC_W-1:0]  off;
   logic              we_mode, we_cmd, we_data, we_int, rd_data_hit;
   logic [DATA_W-1:0] mode_q [NUM_MODE];
   logic [PTR_W-1:0]  ptr_q;
   logic              tx_en, ptr_rst, tx_rst, brk_clr, tx_empty;
   logic [DATA_W-1:0] status, isr, rd_nxt;

   assign off         = bus_addr[DEC_W-1:0];
   assign we_mode     = bus_wr && (off == OFF_MODE);
   assign we_cmd      = bus_wr && (off == OFF_CMD);
   assign we_data     = bus_wr && (off == OFF_DATA);
   assign we_int      = bus_wr && (off == OFF_INT);
   assign rd_data_hit = bus_rd && (off == OFF_DATA);
   assign rxq_pop     = rd_data_hit && rxq_avail;

   uart_regif_cmd u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_we   (we_cmd),
      .cmd_byte (wr_data),
      .tx_en    (tx_en),
      .rx_en    (rx_en),
      .ptr_rst  (ptr_rst),
      .rx_flush (rxq_flush),
      .tx_rst   (tx_rst),
      .brk_clr  (brk_clr)
   );

   uart_regif_tx #(.DATA_W(DATA_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (we_data),
      .load_data (wr_data),
      .tx_en     (tx_en),
      .tx_rst    (tx_rst),
      .tx_ready  (tx_ready),
      .tx_valid  (tx_valid),
      .tx_data   (tx_data),
      .tx_empty  (tx_empty)
   );

   uart_regif_irq #(.DATA_W(DATA_W), .IRQ_REG(IRQ_REG)) u_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .mask_we     (we_int),
      .mask_data   (wr_data),
      .tx_rdy      (tx_en),
      .rx_avail    (rxq_avail),
      .rx_full     (rxq_full),
      .rx_src_full (mode_q[0][MODE_RXSRC_BIT]),
      .brk_set     (brk_evt),
      .brk_clr     (brk_clr),
      .isr         (isr),
      .irq         (irq)
   );

   always_comb begin
      status           = '0;
      status[ST_RXRDY] = rxq_avail;
      status[ST_FULL]  = rxq_full;
      status[ST_TXRDY] = tx_en;
      status[ST_TXEMP] = tx_empty;
   end

   always_comb begin
      case (off)
         OFF_MODE:  rd_nxt = mode_q[ptr_q];
         OFF_STAT:  rd_nxt = status;
         OFF_DATA:  rd_nxt = rxq_avail ? rxq_data : '0;
         OFF_INT:   rd_nxt = isr;
         OFF_BAUDA: rd_nxt = baud_a;
         OFF_BAUDB: rd_nxt = baud_b;
         default:   rd_nxt = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q   <= '0;
         rd_data <= '0;
         for (int i = 0; i < NUM_MODE; i++) mode_q[i] <= '0;
      end else begin
         if (we_mode) begin
            mode_q[ptr_q] <= wr_data;
            ptr_q         <= PTR_W'(NUM_MODE - 1);
         end else if (ptr_rst) begin
            ptr_q <= '0;
         end
         if (bus_rd) rd_data <= rd_nxt;
      end
   end

   AST_POP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      rxq_pop |-> rxq_avail); // R10
   AST_PTR_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      we_mode |=> (ptr_q == PTR_W'(NUM_MODE - 1))); // R2
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(rd_data)); // R12
endmodule

// File: tb/tb_uart_regif.sv
module tb_uart_regif;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] bus_addr = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic [7:0] rxq_data;
   logic       rxq_avail, rxq_full, rxq_pop, rxq_flush, rx_en;
   logic       brk_evt = 1'b0;
   logic [7:0] baud_a = 8'h5A, baud_b = 8'hC3;
   logic       tx_valid, tx_ready = 1'b0, irq;
   logic [7:0] tx_data;

   int tests = 0, fails = 0, cycles = 0;

   always #5 clk = ~clk;

   uart_regif dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .wr_data(wr_data), .rd_data(rd_data),
      .rxq_data(rxq_data), .rxq_avail(rxq_avail), .rxq_full(rxq_full),
      .rxq_pop(rxq_pop), .rxq_flush(rxq_flush), .rx_en(rx_en),
      .brk_evt(brk_evt), .baud_a(baud_a), .baud_b(baud_b),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .irq(irq)
   );

   // four-entry receive FIFO stand-in
   logic [7:0] q [4];
   int         cnt;
   logic       push_req = 1'b0;
   logic [7:0] push_val = '0;
   assign rxq_avail = (cnt != 0);
   assign rxq_full  = (cnt == 4);
   assign rxq_data  = q[0];

   always @(posedge clk) begin
      int n;
      if (!rst_n) cnt <= 0;
      else if (rxq_flush) cnt <= 0;
      else begin
         n = cnt;
         if (rxq_pop && n > 0) begin
            for (int i = 0; i < 3; i++) q[i] <= q[i+1];
            n = n - 1;
         end
         if (push_req && n < 4) begin
            q[n] <= push_val;
            n = n + 1;
         end
         cnt <= n;
      end
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         fails = fails + 1;
         tests = tests + 1;
         $display("FAIL watchdog: act=%0d cycles exp=finish", cycles);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
      tests = tests + 1;
      if (act !== exp) begin
         fails = fails + 1;
         $display("FAIL %s: act=%02h exp=%02h", rq, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; wr_data = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic wr_flush(input logic [7:0] d, output logic fl);
      @(negedge clk);
      bus_addr = 6'h08; wr_data = d; bus_wr = 1'b1;
      #1 fl = rxq_flush;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [7:0] r, output logic pop);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 pop = rxq_pop;
      @(negedge clk);
      bus_rd = 1'b0;
      r = rd_data;
   endtask

   task automatic push(input logic [7:0] v);
      @(negedge clk);
      push_req = 1'b1; push_val = v;
      @(negedge clk);
      push_req = 1'b0;
   endtask

   // {write, offset, data, expected read}
   localparam int NV = 20;
   localparam logic [22:0] TBL [NV] = '{
      {1'b0, 6'h04, 8'h00, 8'h08},  // R1 status after reset
      {1'b0, 6'h14, 8'h00, 8'h00},  // R1 interrupt status
      {1'b0, 6'h00, 8'h00, 8'h00},  // R1 mode reg
      {1'b1, 6'h00, 8'h40, 8'h00},  // R2 first mode reg
      {1'b1, 6'h00, 8'h13, 8'h00},  // R2 second mode reg
      {1'b0, 6'h00, 8'h00, 8'h13},  // R2 pointer advanced
      {1'b1, 6'h00, 8'h17, 8'h00},  // R2 stays on second
      {1'b0, 6'h00, 8'h00, 8'h17},
      {1'b1, 6'h08, 8'h10, 8'h00},  // R2 pointer reset
      {1'b0, 6'h00, 8'h00, 8'h40},
      {1'b1, 6'h04, 8'hFF, 8'h00},  // R11 ignored write
      {1'b0, 6'h04, 8'h00, 8'h08},
      {1'b1, 6'h10, 8'hFF, 8'h00},  // R11 ignored write
      {1'b0, 6'h10, 8'h00, 8'h00},
      {1'b0, 6'h08, 8'h00, 8'h00},  // R11 unmapped read
      {1'b0, 6'h24, 8'h00, 8'h00},
      {1'b0, 6'h18, 8'h00, 8'h5A},  // R11 baud bytes
      {1'b0, 6'h1C, 8'h00, 8'hC3},
      {1'b1, 6'h08, 8'h04, 8'h00},  // R5 tx enable
      {1'b0, 6'h04, 8'h00, 8'h0C}   // R3 ready and empty
   };

   initial begin
      logic [7:0] r;
      logic       p, fl;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 tx_valid", {7'd0, tx_valid}, 8'h00);
      chk("R1 rx_en", {7'd0, rx_en}, 8'h00);
      chk("R1 irq", {7'd0, irq}, 8'h00);

      for (int i = 0; i < NV; i++) begin
         if (TBL[i][22]) wr(TBL[i][21:16], TBL[i][15:8]);
         else begin
            rd(TBL[i][21:16], r, p);
            chk($sformatf("R12 table row %0d", i), r, TBL[i][7:0]);
         end
      end
      chk("R12 rd_data holds", rd_data, 8'h0C);

      // R5 disable / reserved
      wr(6'h08, 8'h08);
      rd(6'h04, r, p); chk("R5 disable", r, 8'h08);
      wr(6'h08, 8'h0C);
      rd(6'h04, r, p); chk("R5 reserved keeps", r, 8'h08);

      // R4 transmit path
      wr(6'h0C, 8'hA5);
      chk("R4 no valid while off", {7'd0, tx_valid}, 8'h00);
      rd(6'h04, r, p); chk("R4 empty cleared", r, 8'h00);
      wr(6'h08, 8'h04);
      chk("R4 valid", {7'd0, tx_valid}, 8'h01);
      chk("R4 data", tx_data, 8'hA5);
      @(negedge clk);
      chk("R4 hold valid", {7'd0, tx_valid}, 8'h01);
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
      chk("R4 accepted", {7'd0, tx_valid}, 8'h00);
      rd(6'h04, r, p); chk("R4 empty set", r, 8'h0C);

      // R7 transmitter reset drops byte
      wr(6'h0C, 8'h3C);
      chk("R7 valid before reset", {7'd0, tx_valid}, 8'h01);
      wr(6'h08, 8'h30);
      chk("R7 tx reset valid", {7'd0, tx_valid}, 8'h00);
      rd(6'h04, r, p); chk("R7 tx reset status", r, 8'h08);
      wr(6'h08, 8'h34);
      rd(6'h04, r, p); chk("R7 reset then enable", r, 8'h0C);

      // R6, R9, R10 receive side (mode bit6 = 1 -> full source)
      wr(6'h08, 8'h01);
      chk("R6 rx enable", {7'd0, rx_en}, 8'h01);
      wr(6'h08, 8'h03);
      chk("R6 reserved keeps", {7'd0, rx_en}, 8'h01);
      push(8'h11); push(8'h22);
      wr(6'h14, 8'h02);
      rd(6'h14, r, p); chk("R9 not full source", r, 8'h01);
      chk("R9 irq masked", {7'd0, irq}, 8'h00);
      push(8'h33); push(8'h44);
      rd(6'h04, r, p); chk("R3 full status", r, 8'h0F);
      chk("R9 irq on full", {7'd0, irq}, 8'h01);
      rd(6'h0C, r, p);
      chk("R10 pop pulse", {7'd0, p}, 8'h01);
      chk("R10 head byte", r, 8'h11);
      chk("R9 irq after pop", {7'd0, irq}, 8'h00);
      wr(6'h08, 8'h10);
      wr(6'h00, 8'h00);
      rd(6'h14, r, p); chk("R9 ready source", r, 8'h03);
      chk("R9 irq ready source", {7'd0, irq}, 8'h01);

      // R7 receiver reset
      wr_flush(8'h20, fl);
      chk("R7 flush pulse", {7'd0, fl}, 8'h01);
      chk("R7 rx off", {7'd0, rx_en}, 8'h00);
      rd(6'h0C, r, p);
      chk("R10 empty read", r, 8'h00);
      chk("R10 no pop", {7'd0, p}, 8'h00);
      wr(6'h08, 8'h21);
      chk("R7 rx reset then enable", {7'd0, rx_en}, 8'h01);

      // R8 break flag
      @(negedge clk); brk_evt = 1'b1;
      @(negedge clk); brk_evt = 1'b0;
      rd(6'h14, r, p); chk("R8 break set", r, 8'h05);
      wr(6'h14, 8'h04);
      chk("R8 irq on break", {7'd0, irq}, 8'h01);
      wr(6'h08, 8'h40);
      rd(6'h14, r, p); chk("R8 code4 no-op", r, 8'h05);
      wr(6'h08, 8'h50);
      rd(6'h14, r, p); chk("R8 break cleared", r, 8'h01);
      chk("R8 irq cleared", {7'd0, irq}, 8'h00);

      // R1 reset again
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd(6'h04, r, p); chk("R1 status after rerun", r, 8'h08);
      chk("R1 rx_en after rerun", {7'd0, rx_en}, 8'h00);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule